// File: doc/BRIEF.md
# Cached-DRAM Refresh and Start-Up Sequencer

This block sits on the host side of a DRAM with an on-chip row cache. It drives the row strobe and mode pins of the memory. After reset it holds the row strobe idle, then plays a fixed start-up script of refresh cycles and two reads to distinct rows, and raises `ready`. From then on it keeps the memory refreshed with cycles that use the memory's internal row counter. It also handles self-refresh entry and exit on request. All pin timings are given in nanoseconds and converted to whole clocks from a clock-period parameter.

Normal accesses are made by a separate access engine. That engine asks through `accReq` and may drive the memory only while `accGrant` is high. A refresh interval that expires during a grant is recorded as a debt. When the grant ends, owed refreshes take priority over a new grant, and they are issued back to back.

Top module: `dram_rfsh_seq`

## Requirements
- R1: In reset `reN`, `refN`, `weN`, `calN` and `selN` are all 1, and `ready` and `accGrant` are 0.
- R2: After reset `reN` stays high for at least `T_PWRUP_NS` (rounded up to clocks) before its first falling edge.
- R3: The start-up script has eight refresh cycles and then two read cycles, for ten row-strobe falls in all. A read fall has `selN`=0, `wrRd`=0 and `refN`=1. The first read drives `rowAddr`=`INIT_ROW_A` (default 0) and the second drives `INIT_ROW_B` (default 1). `ready` rises only after the tenth cycle has finished, and it then stays high until reset.
- R4: A refresh cycle is a `reN` fall with `refN`=0. `refN` goes low at least `T_MODE_SETUP_NS` of clocks before the fall and stays low while `reN` is low. `reN` stays low for `T_RE_NS` of clocks.
- R5: If another refresh follows at once, `reN` stays high after a refresh for the chained precharge (`T_RP_CHAIN_NS`) plus mode setup. After the last refresh of a run it stays high for the lone precharge (`T_RP_LONE_NS`).
- R6: Once ready and idle, one refresh is issued every `REF_INTERVAL_NS`, and consecutive isolated refreshes are exactly that many clocks apart.
- R7: Interval expiries that happen while access is granted are counted as owed refreshes, up to `BACKLOG_MAX`. When the grant ends, all owed refreshes are issued back to back.
- R8: `accGrant` is given only when `ready` is high, the sequencer is idle, `accReq` was high and no refresh is owed. It stays high until `accReq` drops. While it is high, `reN` and `refN` stay high. Owed refresh has priority over both a new grant and self-refresh entry.
- R9: Self-refresh is entered on `srReq` with a `reN` fall while `selN`, `wrRd`, `refN` and `weN` are 1 and `calN` is 0. `reN` then stays low for as long as `srReq` stays high.
- R10: When `srReq` drops, `reN` stays high for at least `T_SR_EXIT_NS` of clocks and is then followed by exactly one refresh. Owed refreshes are cleared and the interval timer restarts at entry, so no further refresh follows within one interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accReq | input | 1 | Access engine asks for the memory |
| accGrant | output | 1 | Access engine may drive the memory |
| srReq | input | 1 | Level request to stay in self-refresh |
| reN | output | 1 | Row strobe, active low |
| refN | output | 1 | Refresh mode line, active low |
| wrRd | output | 1 | Write (1) / read (0) mode line |
| weN | output | 1 | Write enable, active low |
| calN | output | 1 | Column latch strobe, active low |
| selN | output | 1 | Device select, active low |
| rowAddr | output | ROW_W | Row address for the start-up reads |
| ready | output | 1 | Start-up script complete |

## Verification
The bench keeps the 20 ns clock period and sets the refresh interval to 4000 ns, which is 200 clocks. This lets a grant span three intervals, and also span ten intervals so the owed count saturates at eight, all within a few thousand cycles. It sets the chained precharge to 80 ns and the lone precharge to 40 ns (4 and 2 clocks). At the default values both round to the same clock count, so these settings make the two precharge cases visibly different at the pins. The other timings keep their defaults: 2-clock row strobe, 15-clock start-up idle, 5-clock self-refresh exit and 1-clock mode setup.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [3:0] {
    S_PWRUP, S_RF_SETUP, S_RF_ACT, S_RF_PRE,
    S_RD_SETUP, S_RD_ACT, S_RD_PRE,
    S_IDLE, S_GRANT,
    S_SR_SETUP, S_SR_HOLD, S_SR_EXIT
  } seqStateT;

  typedef enum logic [2:0] {
    W_PWRUP, W_SETUP, W_ACT, W_CHAIN, W_LONE, W_SREXIT
  } waitSelT;

  // control -> datapath strobes
  typedef struct packed {
    logic    load;        // reload phase counter
    waitSelT waitSel;     // which phase length to load
    logic    decBacklog;  // one owed refresh issued
    logic    clrBacklog;  // forget debt, restart timer
    logic    timerRun;    // interval timer counts
    logic    incInitRef;  // start-up refresh issued
    logic    incRead;     // advance to second start-up read
    logic    setReady;    // start-up complete
  } seqStrobeT;

  function automatic int ns2cyc(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accReq,
  input  logic      srReq,
  input  logic      waitDone,
  input  logic      backlogNZ,
  input  logic      moreRef,
  input  logic      readIdx,
  input  logic      ready,
  output seqStrobeT stb,
  output logic      accGrant,
  output logic      reN,
  output logic      refN,
  output logic      wrRd,
  output logic      weN,
  output logic      calN,
  output logic      selN
);

  seqStateT state, nextState;
  logic     chainRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_PWRUP;
      chainRef <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_RF_ACT && nextState == S_RF_PRE) chainRef <= moreRef;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_PWRUP:    if (waitDone) nextState = S_RF_SETUP;
      S_RF_SETUP: if (waitDone) nextState = S_RF_ACT;
      S_RF_ACT:   if (waitDone) nextState = S_RF_PRE;
      S_RF_PRE:   if (waitDone) nextState = chainRef ? S_RF_SETUP :
                                            (ready ? S_IDLE : S_RD_SETUP);
      S_RD_SETUP: if (waitDone) nextState = S_RD_ACT;
      S_RD_ACT:   if (waitDone) nextState = S_RD_PRE;
      S_RD_PRE:   if (waitDone) nextState = readIdx ? S_IDLE : S_RD_SETUP;
      S_IDLE: begin
        if (backlogNZ)   nextState = S_RF_SETUP;
        else if (srReq)  nextState = S_SR_SETUP;
        else if (accReq) nextState = S_GRANT;
      end
      S_GRANT:    if (!accReq) nextState = S_IDLE;
      S_SR_SETUP: if (waitDone) nextState = S_SR_HOLD;
      S_SR_HOLD:  if (!srReq) nextState = S_SR_EXIT;
      S_SR_EXIT:  if (waitDone) nextState = S_RF_SETUP;
      default:    nextState = S_PWRUP;
    endcase
  end

  always_comb begin
    stb.load    = (nextState != state);
    stb.waitSel = W_SETUP;
    unique case (nextState)
      S_RF_ACT, S_RD_ACT: stb.waitSel = W_ACT;
      S_RF_PRE:           stb.waitSel = moreRef ? W_CHAIN : W_LONE;
      S_RD_PRE:           stb.waitSel = W_LONE;
      S_SR_EXIT:          stb.waitSel = W_SREXIT;
      default:            stb.waitSel = W_SETUP;
    endcase
    stb.decBacklog = (state == S_RF_SETUP) && (nextState == S_RF_ACT) && ready;
    stb.incInitRef = (state == S_RF_SETUP) && (nextState == S_RF_ACT) && !ready;
    stb.incRead    = (state == S_RD_PRE) && (nextState == S_RD_SETUP);
    stb.setReady   = (state == S_RD_PRE) && (nextState == S_IDLE);
    stb.clrBacklog = (state == S_SR_SETUP) && (nextState == S_SR_HOLD);
    stb.timerRun   = ready && (state != S_SR_SETUP) && (state != S_SR_HOLD)
                     && (state != S_SR_EXIT);
  end

  // pin levels decoded from the registered state
  always_comb begin
    reN = 1'b1; refN = 1'b1; wrRd = 1'b0; weN = 1'b1; calN = 1'b1; selN = 1'b1;
    accGrant = 1'b0;
    unique case (state)
      S_RF_SETUP: refN = 1'b0;
      S_RF_ACT:   begin refN = 1'b0; reN = 1'b0; end
      S_RD_SETUP: selN = 1'b0;
      S_RD_ACT:   begin selN = 1'b0; reN = 1'b0; end
      S_SR_SETUP: begin wrRd = 1'b1; calN = 1'b0; end
      S_SR_HOLD:  begin wrRd = 1'b1; calN = 1'b0; reN = 1'b0; end
      S_GRANT:    accGrant = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/rfsh_dpath.sv
module rfsh_dpath
  import rfsh_pkg::*;
#(
  parameter int N_PWRUP     = 15,
  parameter int N_SETUP     = 1,
  parameter int N_RE        = 2,
  parameter int N_CHAIN     = 2,
  parameter int N_LONE      = 2,
  parameter int N_SREXIT    = 5,
  parameter int N_INTV      = 3125,
  parameter int BACKLOG_MAX = 8,
  parameter int INIT_REFS   = 8,
  parameter int ROW_W       = 11,
  parameter int INIT_ROW_A  = 0,
  parameter int INIT_ROW_B  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        stb,
  output logic             waitDone,
  output logic             backlogNZ,
  output logic             moreRef,
  output logic             readIdx,
  output logic             ready,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int N_MAX = maxOf(maxOf(maxOf(N_PWRUP, N_SETUP), maxOf(N_RE, N_CHAIN)),
                               maxOf(N_LONE, N_SREXIT));
  localparam int CNT_W = $clog2(N_MAX + 1);
  localparam int TMR_W = $clog2(N_INTV + 1);
  localparam int BL_W  = $clog2(BACKLOG_MAX + 1);
  localparam int IR_W  = $clog2(INIT_REFS + 1);

  logic [CNT_W-1:0] waitCnt, loadVal;
  logic [TMR_W-1:0] tmr;
  logic [BL_W-1:0]  backlog;
  logic [IR_W-1:0]  initRefCnt;
  logic             tick, incBl, decBl;

  always_comb begin
    unique case (stb.waitSel)
      W_PWRUP:  loadVal = CNT_W'(N_PWRUP - 1);
      W_ACT:    loadVal = CNT_W'(N_RE - 1);
      W_CHAIN:  loadVal = CNT_W'(N_CHAIN - 1);
      W_LONE:   loadVal = CNT_W'(N_LONE - 1);
      W_SREXIT: loadVal = CNT_W'(N_SREXIT - 1);
      default:  loadVal = CNT_W'(N_SETUP - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               waitCnt <= CNT_W'(N_PWRUP - 1);
    else if (stb.load)       waitCnt <= loadVal;
    else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  // refresh interval timer and owed-refresh count
  assign tick  = stb.timerRun && (tmr == TMR_W'(N_INTV - 1));
  assign decBl = stb.decBacklog && (backlog != '0);
  assign incBl = tick && ((backlog != BL_W'(BACKLOG_MAX)) || decBl);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrBacklog) begin
      tmr     <= '0;
      backlog <= '0;
    end else begin
      if (stb.timerRun) tmr <= tick ? '0 : tmr + 1'b1;
      if (incBl && !decBl)      backlog <= backlog + 1'b1;
      else if (decBl && !incBl) backlog <= backlog - 1'b1;
    end
  end
  assign backlogNZ = (backlog != '0);

  // start-up script progress
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initRefCnt <= '0;
      readIdx    <= 1'b0;
      ready      <= 1'b0;
    end else begin
      if (stb.incInitRef) initRefCnt <= initRefCnt + 1'b1;
      if (stb.incRead)    readIdx    <= 1'b1;
      if (stb.setReady)   ready      <= 1'b1;
    end
  end

  assign moreRef = ready ? backlogNZ : (initRefCnt < IR_W'(INIT_REFS));
  assign rowAddr = readIdx ? ROW_W'(INIT_ROW_B) : ROW_W'(INIT_ROW_A);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int CLK_PERIOD_NS   = 20,
  parameter int REF_INTERVAL_NS = 62500,
  parameter int T_RE_NS         = 30,
  parameter int T_RP_CHAIN_NS   = 40,
  parameter int T_RP_LONE_NS    = 25,
  parameter int T_PWRUP_NS      = 300,
  parameter int T_SR_EXIT_NS    = 100,
  parameter int T_MODE_SETUP_NS = 5,
  parameter int BACKLOG_MAX     = 8,
  parameter int INIT_REFS       = 8,
  parameter int ROW_W           = 11,
  parameter int INIT_ROW_A      = 0,
  parameter int INIT_ROW_B      = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accReq,
  output logic             accGrant,
  input  logic             srReq,
  output logic             reN,
  output logic             refN,
  output logic             wrRd,
  output logic             weN,
  output logic             calN,
  output logic             selN,
  output logic [ROW_W-1:0] rowAddr,
  output logic             ready
);

  localparam int N_RE     = ns2cyc(T_RE_NS, CLK_PERIOD_NS);
  localparam int N_CHAIN  = ns2cyc(T_RP_CHAIN_NS, CLK_PERIOD_NS);
  localparam int N_LONE   = ns2cyc(T_RP_LONE_NS, CLK_PERIOD_NS);
  localparam int N_PWRUP  = ns2cyc(T_PWRUP_NS, CLK_PERIOD_NS);
  localparam int N_SREXIT = ns2cyc(T_SR_EXIT_NS, CLK_PERIOD_NS);
  localparam int N_SETUP  = ns2cyc(T_MODE_SETUP_NS, CLK_PERIOD_NS);
  localparam int N_INTV   = maxOf(2, ns2cyc(REF_INTERVAL_NS, CLK_PERIOD_NS));

  seqStrobeT stb;
  logic      waitDone, backlogNZ, moreRef, readIdx;

  rfsh_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .accReq(accReq), .srReq(srReq),
    .waitDone(waitDone), .backlogNZ(backlogNZ), .moreRef(moreRef),
    .readIdx(readIdx), .ready(ready), .stb(stb), .accGrant(accGrant),
    .reN(reN), .refN(refN), .wrRd(wrRd), .weN(weN), .calN(calN), .selN(selN)
  );

  rfsh_dpath #(
    .N_PWRUP(N_PWRUP), .N_SETUP(N_SETUP), .N_RE(N_RE), .N_CHAIN(N_CHAIN),
    .N_LONE(N_LONE), .N_SREXIT(N_SREXIT), .N_INTV(N_INTV),
    .BACKLOG_MAX(BACKLOG_MAX), .INIT_REFS(INIT_REFS), .ROW_W(ROW_W),
    .INIT_ROW_A(INIT_ROW_A), .INIT_ROW_B(INIT_ROW_B)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .waitDone(waitDone),
    .backlogNZ(backlogNZ), .moreRef(moreRef), .readIdx(readIdx),
    .ready(ready), .rowAddr(rowAddr)
  );

endmodule

// File: rtl/rfsh_checks.sv
module rfsh_checks (
  input logic clk,
  input logic rstN,
  input logic accReq,
  input logic accGrant,
  input logic reN,
  input logic refN,
  input logic wrRd,
  input logic weN,
  input logic calN,
  input logic selN,
  input logic ready
);

  // R4: refresh mode line set up before the row strobe falls
  p_ref_setup_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(reN) && !refN) |-> $past(!refN));

  // R4: refresh mode line held through the low phase
  p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!reN && $past(!reN) && $past(!refN)) |-> !refN);

  // R3: ready never falls once raised
  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R8: grant only after start-up and leaves the pins quiet
  p_grant_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (ready && reN && refN));

  // R8: grant follows a request
  p_grant_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accGrant) |-> $past(accReq));

  // R9: self-refresh entry levels
  p_sr_pins_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(reN) && !calN) |-> (selN && wrRd && refN && weN));

endmodule

bind dram_rfsh_seq rfsh_checks chk_i (
  .clk(clk), .rstN(rstN), .accReq(accReq), .accGrant(accGrant),
  .reN(reN), .refN(refN), .wrRd(wrRd), .weN(weN), .calN(calN),
  .selN(selN), .ready(ready)
);

// File: tb/dram_rfsh_seq_tb_top.sv
module dram_rfsh_seq_tb_top;

  localparam int C_CHAIN = 4, C_LONE = 2, C_SETUP = 1, C_RE = 2;
  localparam int C_PWRUP = 15, C_SREXIT = 5, C_INTV = 200;
  localparam int K_REF = 1, K_RD = 2, K_SR = 3;

  logic clk = 1'b0, rstN = 1'b0, accReq = 1'b0, srReq = 1'b0;
  logic accGrant, reN, refN, wrRd, weN, calN, selN, ready;
  logic [10:0] rowAddr;

  always #10 clk = ~clk;

  dram_rfsh_seq #(
    .REF_INTERVAL_NS(4000), .T_RP_CHAIN_NS(80), .T_RP_LONE_NS(40)
  ) dut_i (
    .clk(clk), .rstN(rstN), .accReq(accReq), .accGrant(accGrant),
    .srReq(srReq), .reN(reN), .refN(refN), .wrRd(wrRd), .weN(weN),
    .calN(calN), .selN(selN), .rowAddr(rowAddr), .ready(ready)
  );

  // pin monitor: one record per row-strobe fall
  int evKind[128], evHigh[128], evLow[128], evRow[128], evCyc[128];
  bit evSetup[128], evReady[128];
  int evCount = 0, cyc = 0, highRun = 0, lowRun = 0;
  logic pReN = 1'b1, pRefN = 1'b1, pSelN = 1'b1, pWrRd = 1'b0, pCalN = 1'b1;

  always @(negedge clk) begin
    if (!rstN) begin
      highRun = 0; lowRun = 0; pReN = 1'b1;
    end else begin
      cyc++;
      if (pReN && !reN && evCount < 128) begin
        evHigh[evCount] = highRun;
        evRow[evCount]  = int'(rowAddr);
        evCyc[evCount]  = cyc;
        evReady[evCount] = ready;
        if (!refN) begin
          evKind[evCount] = K_REF; evSetup[evCount] = !pRefN;
        end else if (!selN && !wrRd) begin
          evKind[evCount] = K_RD; evSetup[evCount] = !pSelN && !pWrRd;
        end else if (selN && wrRd && weN && !calN) begin
          evKind[evCount] = K_SR; evSetup[evCount] = !pCalN;
        end else begin
          evKind[evCount] = 0; evSetup[evCount] = 1'b0;
        end
        lowRun = 1;
        evCount++;
      end else if (!reN) lowRun++;
      if (!pReN && reN) begin
        if (evCount > 0) evLow[evCount-1] = lowRun;
        highRun = 1;
      end else if (reN) highRun++;
    end
    pReN = reN; pRefN = refN; pSelN = selN; pWrRd = wrRd; pCalN = calN;
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic waitEv(input int target, input int limit);
    for (int i = 0; i < limit && evCount < target; i++) tick(1);
  endtask

  task automatic waitGrant(input int limit);
    for (int i = 0; i < limit && !accGrant; i++) tick(1);
  endtask

  task automatic t_reset;
    tick(3);
    chk(reN && refN && weN && calN && selN, "R1 strobes idle", {reN, refN, weN, calN, selN}, 31);
    chk(!ready, "R1 ready low", ready, 0);
    chk(!accGrant, "R1 grant low", accGrant, 0);
  endtask

  task automatic t_init;
    waitEv(10, 400);
    chk(evCount == 10, "R3 ten start-up cycles", evCount, 10);
    chk(evHigh[0] >= C_PWRUP, "R2 power-up idle", evHigh[0], C_PWRUP);
    for (int i = 0; i < 8; i++) begin
      chk(evKind[i] == K_REF, "R3 refresh in script", evKind[i], K_REF);
      chk(evSetup[i], "R4 mode setup", evSetup[i], 1);
      chk(evLow[i] == C_RE, "R4 row strobe width", evLow[i], C_RE);
    end
    for (int i = 1; i < 8; i++)
      chk(evHigh[i] == C_CHAIN + C_SETUP, "R5 chained precharge", evHigh[i], C_CHAIN + C_SETUP);
    chk(evHigh[8] == C_LONE + C_SETUP, "R5 lone precharge", evHigh[8], C_LONE + C_SETUP);
    chk(evKind[8] == K_RD && evKind[9] == K_RD, "R3 two reads", evKind[9], K_RD);
    chk(evSetup[8] && evSetup[9], "R3 read mode lines", evSetup[9], 1);
    chk(evRow[8] == 0, "R3 first read row", evRow[8], 0);
    chk(evRow[9] == 1, "R3 second read row", evRow[9], 1);
    chk(!evReady[9], "R3 ready not early", evReady[9], 0);
    tick(10);
    chk(ready, "R3 ready after script", ready, 1);
  endtask

  task automatic t_periodic;
    waitEv(13, 1200);
    chk(evCount >= 13, "R6 periodic refresh issued", evCount, 13);
    for (int i = 10; i < 12; i++) begin
      chk(evKind[i+1] == K_REF, "R6 kind", evKind[i+1], K_REF);
      chk(evCyc[i+1] - evCyc[i] == C_INTV, "R6 spacing", evCyc[i+1] - evCyc[i], C_INTV);
    end
  endtask

  task automatic t_backlog(input int hold, input int exp);
    int c0, base;
    c0 = evCount;
    waitEv(c0 + 1, 400);
    tick(1);
    accReq = 1'b1;
    tick(hold);
    chk(accGrant, "R8 grant held", accGrant, 1);
    chk(evCount == c0 + 1, "R8 no row cycle while granted", evCount - c0, 1);
    accReq = 1'b0;
    tick(1);
    accReq = 1'b1;
    base = evCount;
    waitGrant(300);
    chk(evCount - base == exp, "R7 owed refreshes drained before grant", evCount - base, exp);
    for (int i = 1; i < exp; i++)
      chk(evHigh[base+i] == C_CHAIN + C_SETUP, "R5 chained precharge in drain",
          evHigh[base+i], C_CHAIN + C_SETUP);
    accReq = 1'b0;
    tick(5);
  endtask

  task automatic t_selfref;
    int c;
    waitEv(evCount + 1, 400);
    tick(20);
    srReq = 1'b1;
    c = evCount;
    tick(10);
    chk(evCount == c + 1, "R9 self-refresh entered", evCount - c, 1);
    chk(evKind[c] == K_SR && evSetup[c], "R9 entry levels", evKind[c], K_SR);
    tick(700);
    chk(!reN && evCount == c + 1, "R9 strobe held low", reN, 0);
    srReq = 1'b0;
    tick(20);
    chk(evCount == c + 2 && evKind[c+1] == K_REF, "R10 refresh after exit", evKind[c+1], K_REF);
    chk(evHigh[c+1] >= C_SREXIT, "R10 exit idle", evHigh[c+1], C_SREXIT);
    chk(evLow[c] >= 700, "R9 low time", evLow[c], 700);
    tick(150);
    chk(evCount == c + 2, "R10 debt cleared", evCount - c, 2);
  endtask

  initial begin
    tick(2);
    t_reset;
    rstN = 1'b1;
    t_init;
    t_periodic;
    t_backlog(700, 3);
    t_backlog(2100, 8);
    t_selfref;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule